// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block connects a clocked host to a 32K x 8 static RAM that has no clock and a single shared byte lane for data. The host hands over one access at a time on a valid/ready handshake. A request carries a write flag, a 15-bit word address and, for stores, a data byte. The controller then drives the memory's active-low chip select, write strobe and output-enable strobe. It splits the shared data pad into an output byte, a driver enable and an input byte, and returns the loaded byte in a register together with a one-cycle valid pulse.

Every timing window on the memory side is a whole number of clock cycles set by a parameter. `TWP` sets how long the write strobe is held low. `TDW` sets how many of those cycles carry driven data. `TRD` sets how many cycles pass between opening a read and sampling the pad. `TTURN` sets the idle gap placed between a read and the write after it. With the defaults (2, 1, 2, 1) the block meets the fastest memory grade from a 100 MHz clock. Stores are ended by the write strobe and never by the chip select. The controller only drives the pad once the memory's outputs are known to be off, so the two sides never drive the byte lane at the same time.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and right after synchronous reset, chip select, write strobe and output-enable strobe are all high (inactive), the pad driver is off, `rdValid` is 0 and `reqReady` is 1.
- R2: `reqReady` is 1 only while no access, recovery or turnaround is in progress. While it is 1, all three strobes are high and the driver is off. A request presented while `reqReady` is 0 is not taken.
- R3: A read taken at a clock edge drives the address, chip select low and output enable low from the next cycle for exactly `TRD` cycles. The write strobe stays high throughout.
- R4: At the end of the `TRD` window the pad byte is loaded into `rdData`. From that cycle on, chip select and output enable are high, `reqReady` is 1 and `rdValid` is 1 for exactly one cycle.
- R5: A write drives the address, chip select low, write strobe low and output enable high for exactly `TWP` consecutive cycles.
- R6: During a write, the pad driver is on only in the last `TDW` cycles of the write-strobe-low window. It is never on in the first cycle of that window, and it turns off in the same cycle the write strobe returns high. This assumes 1 <= `TDW` < `TWP`.
- R7: Each write ends with exactly one cycle in which chip select is low, the write strobe is high and the driver is off. The controller then returns to idle with chip select high.
- R8: A write whose preceding access since reset was a read first spends `TTURN` cycles with all strobes high, the driver off and `reqReady` 0. A write that follows a write, or the first access after reset, has no such gap.
- R9: A byte written to an address is the byte a later read of that address returns in `rdData`.
- R10: The pad driver is never on while output enable is low.
- R11: The memory address stays constant over every cycle of an access in which chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host presents a request |
| reqReady | output | 1 | Controller can take a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Word address |
| reqWdata | input | 8 | Byte to store |
| rdData | output | 8 | Last byte loaded from memory |
| rdValid | output | 1 | One-cycle pulse: `rdData` was just loaded |
| sramAddr | output | 15 | Address to memory |
| sramCeN | output | 1 | Chip select, active low |
| sramWeN | output | 1 | Write strobe, active low |
| sramOeN | output | 1 | Output-enable strobe, active low |
| sramDqOut | output | 8 | Byte driven onto the shared pad |
| sramDqOe | output | 1 | Pad driver enable, active high |
| sramDqIn | input | 8 | Byte read from the shared pad |

## Verification
If the state register or the window counter is corrupted, the strobe pattern goes wrong on the very next cycle. A strobe falls too early or stays low too long, or `reqReady` rises in the middle of an access. A lost read-before-write flag shows as a missing or extra block of `TTURN` all-high cycles ahead of the write strobe. A wrong sampling point or a lost stored byte appears at the latest when that address is read back, as a mismatch in `rdData` in the `rdValid` cycle. Because every memory-side pin is compared with a reference schedule on every clock, a single-cycle slip is caught in the cycle where it occurs.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_WREC
  } ctrlState_t;

  // Strobes from control to datapath; pad levels are next-cycle values.
  typedef struct packed {
    logic loadReq;
    logic capture;
    logic ceN;
    logic weN;
    logic oeN;
    logic dqOe;
  } padCmd_t;

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int TWP   = 2,
  parameter int TDW   = 1,
  parameter int TRD   = 2,
  parameter int TTURN = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output padCmd_t cmd
);

  localparam int MAX_A = (TWP > TRD) ? TWP : TRD;
  localparam int MAX_W = (MAX_A > TTURN) ? MAX_A : TTURN;
  localparam int CNT_W = (MAX_W < 2) ? 1 : $clog2(MAX_W + 1);

  localparam logic [CNT_W-1:0] LAST_RD   = CNT_W'(TRD - 1);
  localparam logic [CNT_W-1:0] LAST_WP   = CNT_W'(TWP - 1);
  localparam logic [CNT_W-1:0] LAST_TURN = CNT_W'(TTURN - 1);
  localparam logic [CNT_W:0]   DRV_AT    = (CNT_W + 1)'(TWP - TDW);
  localparam bit               HAS_TURN  = (TTURN > 0);

  ctrlState_t        state, nState;
  logic [CNT_W-1:0]  cnt, nCnt;
  logic [CNT_W:0]    cntInc;
  logic              lastRead, nLastRead;

  assign cntInc   = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    nState    = state;
    nCnt      = cnt;
    nLastRead = lastRead;
    cmd       = '0;
    cmd.ceN   = 1'b1;
    cmd.weN   = 1'b1;
    cmd.oeN   = 1'b1;
    cmd.dqOe  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          cmd.loadReq = 1'b1;
          nCnt        = '0;
          if (!reqWrite) begin
            nState  = ST_READ;
            cmd.ceN = 1'b0;
            cmd.oeN = 1'b0;
          end else if (lastRead && HAS_TURN) begin
            nState = ST_TURN;
          end else begin
            nState  = ST_WRITE;
            cmd.ceN = 1'b0;
            cmd.weN = 1'b0;
          end
        end
      end
      ST_READ: begin
        if (cnt == LAST_RD) begin
          cmd.capture = 1'b1;
          nLastRead   = 1'b1;
          nState      = ST_IDLE;
        end else begin
          nCnt    = cntInc[CNT_W-1:0];
          cmd.ceN = 1'b0;
          cmd.oeN = 1'b0;
        end
      end
      ST_TURN: begin
        if (cnt == LAST_TURN) begin
          nState  = ST_WRITE;
          nCnt    = '0;
          cmd.ceN = 1'b0;
          cmd.weN = 1'b0;
        end else begin
          nCnt = cntInc[CNT_W-1:0];
        end
      end
      ST_WRITE: begin
        cmd.ceN = 1'b0;
        if (cnt == LAST_WP) begin
          nState    = ST_WREC;
          nLastRead = 1'b0;
        end else begin
          nCnt     = cntInc[CNT_W-1:0];
          cmd.weN  = 1'b0;
          cmd.dqOe = (cntInc >= DRV_AT);
        end
      end
      ST_WREC: begin
        nState = ST_IDLE;
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
    end else begin
      state    <= nState;
      cnt      <= nCnt;
      lastRead <= nLastRead;
    end
  end

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  padCmd_t           cmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  // Pad strobes: registered straight from the command so every pin is glitch free.
  always_ff @(posedge clk) begin
    if (rst) begin
      sramCeN  <= 1'b1;
      sramWeN  <= 1'b1;
      sramOeN  <= 1'b1;
      sramDqOe <= 1'b0;
    end else begin
      sramCeN  <= cmd.ceN;
      sramWeN  <= cmd.weN;
      sramOeN  <= cmd.oeN;
      sramDqOe <= cmd.dqOe;
    end
  end

  // Request holding registers: stay put for the whole access.
  always_ff @(posedge clk) begin
    if (rst) begin
      sramAddr  <= '0;
      sramDqOut <= '0;
    end else if (cmd.loadReq) begin
      sramAddr  <= reqAddr;
      sramDqOut <= reqWdata;
    end
  end

  // Read return.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= cmd.capture;
      if (cmd.capture) rdData <= sramDqIn;
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int TWP    = 2,
  parameter int TDW    = 1,
  parameter int TRD    = 2,
  parameter int TTURN  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  padCmd_t padCmd;

  sram_ctrl_fsm #(
    .TWP  (TWP),
    .TDW  (TDW),
    .TRD  (TRD),
    .TTURN(TTURN)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .cmd     (padCmd)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .cmd      (padCmd),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .sramDqIn (sramDqIn),
    .sramAddr (sramAddr),
    .sramDqOut(sramDqOut),
    .sramCeN  (sramCeN),
    .sramWeN  (sramWeN),
    .sramOeN  (sramOeN),
    .sramDqOe (sramDqOe),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rdValid,
  input logic              sramCeN,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic              sramDqOe,
  input logic [ADDR_W-1:0] sramAddr
);

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (sramCeN && sramWeN && sramOeN && !sramDqOe));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady);

  assert_read_we_high_R3: assert property (@(posedge clk) disable iff (rst)
    !sramOeN |-> (sramWeN && !sramCeN));

  assert_rdvalid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  assert_rdvalid_release_R4: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> (sramCeN && sramOeN && reqReady));

  assert_drv_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    sramDqOe |-> (!sramWeN && !sramCeN));

  assert_drv_after_we_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sramDqOe) |-> $past(!sramWeN));

  assert_drv_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sramWeN) |-> !sramDqOe);

  assert_we_end_ce_low_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sramWeN) |-> !sramCeN);

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
    sramDqOe |-> sramOeN);

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

endmodule

bind sram_bus_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .rdValid (rdValid),
  .sramCeN (sramCeN),
  .sramWeN (sramWeN),
  .sramOeN (sramOeN),
  .sramDqOe(sramDqOe),
  .sramAddr(sramAddr)
);

// File: tb/sram_bus_ctrl_tb_top.sv
module sram_bus_ctrl_tb_top;

  localparam int AW      = 15;
  localparam int DW      = 8;
  localparam int P_TWP   = 3;
  localparam int P_TDW   = 2;
  localparam int P_TRD   = 2;
  localparam int P_TTURN = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] rdData;
  logic          rdValid;
  logic [AW-1:0] sramAddr;
  logic          sramCeN, sramWeN, sramOeN, sramDqOe;
  logic [DW-1:0] sramDqOut;
  logic [DW-1:0] sramDqIn = '0;

  always #10 clk = ~clk;

  sram_bus_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .TWP(P_TWP), .TDW(P_TDW), .TRD(P_TRD), .TTURN(P_TTURN)
  ) dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .rdValid(rdValid), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  typedef struct {
    bit          ceN, weN, oeN, dqOe, ready, rv;
    bit          chkAddr, chkDout;
    logic [AW-1:0] addr;
    logic [DW-1:0] dout;
    logic [DW-1:0] rd;
    string       tag;
  } expCyc_t;

  expCyc_t      expQ[$];
  logic [DW-1:0] refMem[int];
  logic [DW-1:0] devMem[int];
  bit           refLastRead = 1'b0;
  bit           lastReady = 1'b1;
  bit           prevWeN = 1'b1;
  logic [DW-1:0] lastDrv = '0;
  int           junk = 0;
  int           checks = 0;
  int           errors = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic expCyc_t idleCyc(string tag);
    expCyc_t e;
    e.ceN = 1; e.weN = 1; e.oeN = 1; e.dqOe = 0; e.ready = 1; e.rv = 0;
    e.chkAddr = 0; e.chkDout = 0; e.addr = '0; e.dout = '0; e.rd = '0; e.tag = tag;
    return e;
  endfunction

  function automatic logic [DW-1:0] memRead(logic [DW-1:0] m[int], int a);
    return m.exists(a) ? m[a] : 8'h00;
  endfunction

  task automatic compareCycle(string idleTag);
    expCyc_t e;
    e = (expQ.size() > 0) ? expQ.pop_front() : idleCyc(idleTag);
    check({sramCeN, sramWeN, sramOeN, sramDqOe} == {e.ceN, e.weN, e.oeN, e.dqOe}, e.tag,
          "strobes{ce,we,oe,drv}", {sramCeN, sramWeN, sramOeN, sramDqOe},
          {e.ceN, e.weN, e.oeN, e.dqOe});
    check(reqReady == e.ready, "R2", "reqReady", reqReady, e.ready);
    check(rdValid == e.rv, "R4", "rdValid", rdValid, e.rv);
    if (e.rv) check(rdData == e.rd, "R9", "rdData", rdData, e.rd);
    if (e.chkAddr) check(sramAddr == e.addr, "R11", "sramAddr", sramAddr, e.addr);
    if (e.chkDout) check(sramDqOut == e.dout, "R6", "sramDqOut", sramDqOut, e.dout);
    lastReady = e.ready;
  endtask

  // Memory device model, updated between edges.
  task automatic deviceStep();
    if (sramDqOe) check(sramOeN, "R10", "pad contention (oeN)", sramOeN, 1);
    if (!prevWeN && sramWeN && !sramCeN) devMem[int'(sramAddr)] = lastDrv;
    if (sramDqOe) lastDrv = sramDqOut;
    prevWeN = sramWeN;
    sramDqIn = (!sramCeN && sramWeN && !sramOeN) ? memRead(devMem, int'(sramAddr)) : 8'h5A;
  endtask

  task automatic nextCycle(string idleTag = "R2");
    @(negedge clk);
    compareCycle(idleTag);
    deviceStep();
    // R2: while busy, present junk requests that must be ignored
    if (!lastReady) begin
      junk++;
      reqValid = 1'b1;
      reqWrite = junk[0];
      reqAddr  = AW'(junk * 1237);
      reqWdata = DW'(junk * 91);
    end else begin
      reqValid = 1'b0;
    end
  endtask

  task automatic pushAccess(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    expCyc_t e;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    if (!wr) begin
      for (int c = 0; c < P_TRD; c++) begin
        e = idleCyc("R3");
        e.ceN = 0; e.oeN = 0; e.ready = 0; e.chkAddr = 1; e.addr = a;
        expQ.push_back(e);
      end
      e = idleCyc("R4");
      e.rv = 1; e.rd = memRead(refMem, int'(a));
      expQ.push_back(e);
      refLastRead = 1'b1;
    end else begin
      if (refLastRead) begin
        for (int c = 0; c < P_TTURN; c++) begin
          e = idleCyc("R8");
          e.ready = 0;
          expQ.push_back(e);
        end
      end
      for (int c = 0; c < P_TWP; c++) begin
        e = idleCyc((c >= P_TWP - P_TDW) ? "R6" : "R5");
        e.ceN = 0; e.weN = 0; e.ready = 0; e.chkAddr = 1; e.addr = a;
        e.dqOe = (c >= P_TWP - P_TDW);
        e.chkDout = e.dqOe; e.dout = d;
        expQ.push_back(e);
      end
      e = idleCyc("R7");
      e.ceN = 0; e.ready = 0; e.chkAddr = 1; e.addr = a;
      expQ.push_back(e);
      refMem[int'(a)] = d;
      refLastRead = 1'b0;
    end
  endtask

  task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    pushAccess(wr, a, d);
    do nextCycle(); while (expQ.size() > 0 || !lastReady);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1: reset state, held over several cycles
    repeat (3) nextCycle("R1");
    rst = 1'b0;
    nextCycle("R1");

    // R5 R6 R7: first writes (no turnaround after reset), back to back
    access(1'b1, 15'h0000, 8'h3C);
    access(1'b1, 15'h7FFF, 8'hC3);
    // R3 R4 R9: reads back to back, second issued in rdValid cycle
    access(1'b0, 15'h0000, 8'h00);
    access(1'b0, 15'h7FFF, 8'h00);
    // R8: write right after read
    access(1'b1, 15'h1234, 8'hA5);
    repeat (3) nextCycle();
    access(1'b0, 15'h1234, 8'h00);
    // R8: write after read with idle gap still gets turnaround
    repeat (4) nextCycle();
    access(1'b1, 15'h0555, 8'h00);
    // R9: pattern sweep, mixed write/read
    for (int i = 0; i < 6; i++) access(1'b1, AW'(i * 4369 + 7), DW'(i * 37 + 1));
    for (int i = 5; i >= 0; i--) access(1'b0, AW'(i * 4369 + 7), 8'h00);
    access(1'b0, 15'h0555, 8'h00);

    // R1: reset in the middle of a read
    pushAccess(1'b0, 15'h7FFF, 8'h00);
    nextCycle();
    nextCycle();
    rst = 1'b1;
    reqValid = 1'b0;
    expQ.delete();
    refLastRead = 1'b0;
    nextCycle("R1");
    rst = 1'b0;
    reqValid = 1'b0;
    nextCycle("R1");
    // R8: after reset the write has no turnaround
    access(1'b1, 15'h2AAA, 8'h99);
    access(1'b0, 15'h2AAA, 8'h00);
    access(1'b0, 15'h7FFF, 8'h00);
    repeat (2) nextCycle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule